// File: doc/BRIEF.md
# USB-C Source Attach Sequencer

This block sequences power-up of a source-only USB-C port. Each CC pin arrives as three comparator flags from the analog front end: in the sink pull-down window, in the cable-marker window, or open (above the disconnect level). When exactly one pin sits in the sink window, the block treats that pin as the sink connection and latches it as the cable orientation. The attach must then stay unchanged for a debounce period counted in millisecond ticks.

After the debounce, the block asserts the enable for the external DC-DC converter and a 5 V default request, but only once the connector VBUS reads as discharged. A fixed number of ticks later it closes the USB 2.0 data switch. Both outputs drop when the active pin stays open for a short detach debounce, when the fault input is raised, or on reset. A pull-up-off input from the fault manager blocks any new attach while it is high.

All control and status pins are plain levels, and the block has no streaming interface. The tick input is a one-cycle pulse, one per millisecond.

Top module: `cas_attach_seq`

## Requirements
- R1: A pin counts as a sink pin when its sink-window flag is 1 and its marker and open flags are 0, and an attach starts only when exactly one pin is a sink pin. `orient` reports the latched pin (0 = CC1 = bit 0, 1 = CC2 = bit 1) while a sequence is active, and reads 0 when idle.
- R2: A pin whose marker flag is set is never taken as the sink pin, so an Rd pin on one side and a marker on the other gives an attach with the orientation of the Rd pin. When both pins are sink pins, no attach occurs.
- R3: `conv_en` rises only after the same single sink pin has been held through `ATTACH_MS` ticks. Any break in the pattern, or a change of pin, during that time returns the block to idle, and the count restarts.
- R4: When the debounce ends while `vbus_safe0v` is 0, `conv_en` stays low until `vbus_safe0v` reads 1, provided the sink pin is still present. If the sink pin goes away first, the block returns to idle.
- R5: `dsw_en` rises `DSW_MS` ticks after `conv_en` rises. It stays high only while `conv_en` is high.
- R6: Detach happens when the open flag of the active pin stays set for `DETACH_MS` consecutive ticks, and `conv_en` and `dsw_en` then fall together. A shorter open interval has no effect.
- R7: While `fault` is 1, both enables are low from the next clock onward, and no attach can start.
- R8: While `cc_pu_off` is 1, no attach can start, and an attach debounce in progress is abandoned.
- R9: `req_5v` is high in exactly the cycles in which `conv_en` is high.
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cc_rd | input | 2 | Per-pin flag: voltage in sink pull-down window (bit 0 = CC1) |
| cc_ra | input | 2 | Per-pin flag: voltage in cable-marker window |
| cc_open | input | 2 | Per-pin flag: voltage above disconnect level |
| vbus_safe0v | input | 1 | Connector VBUS is discharged |
| fault | input | 1 | Protection fault from the fault manager |
| cc_pu_off | input | 1 | Pull-ups disabled by the fault manager; blocks attach |
| conv_en | output | 1 | DC-DC converter enable |
| dsw_en | output | 1 | USB 2.0 data switch enable |
| orient | output | 1 | Active CC pin, 0 = CC1, 1 = CC2 |
| req_5v | output | 1 | Request for the 5 V default output voltage |

## Verification
Every output is a decode of the registered state, so each result shows up one clock after the edge that samples the deciding input level or the tick that completes a count: debounce completion, data-switch delay, detach count, fault and VBUS gating. The bench runs a reference model, written from the requirements, that updates on that same rising edge. It compares all four outputs on every falling edge, so each result is checked in exactly the cycle it is due. Because the checks run every cycle, any change that arrives one cycle early or late is reported on its own.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEB  = 3'd1,
    ST_HOLD = 3'd2,
    ST_PWR  = 3'd3,
    ST_DATA = 3'd4
  } cas_state_e;
endpackage

// File: rtl/cas_pin_decode.sv
module cas_pin_decode #(
  parameter int NPINS = 2,
  localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [NPINS-1:0] rd,
  input  logic [NPINS-1:0] ra,
  input  logic [NPINS-1:0] open_f,
  output logic [NPINS-1:0] sink,
  output logic             single,
  output logic [IDXW-1:0]  sink_idx
);
  // a pin in the marker window is never a sink pin
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign sink[g] = rd[g] & ~ra[g] & ~open_f[g];
  end

  assign single = ($countones(sink) == 1);

  always_comb begin
    sink_idx = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (sink[i]) sink_idx = i[IDXW-1:0];
    end
  end
endmodule

// File: rtl/cas_tick_timer.sv
module cas_tick_timer #(
  parameter int LIMIT = 150,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (tick && !done)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/cas_attach_seq.sv
module cas_attach_seq
  import cas_pkg::*;
#(
  parameter int ATTACH_MS = 150,
  parameter int DETACH_MS = 4,
  parameter int DSW_MS    = 900
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [1:0] cc_rd,
  input  logic [1:0] cc_ra,
  input  logic [1:0] cc_open,
  input  logic       vbus_safe0v,
  input  logic       fault,
  input  logic       cc_pu_off,
  output logic       conv_en,
  output logic       dsw_en,
  output logic       orient,
  output logic       req_5v
);
  localparam int NPINS = 2;

  cas_state_e state, state_nx;
  logic [NPINS-1:0] sink;
  logic             single;
  logic             sink_idx;
  logic             orient_q;
  logic             deb_done, dsw_done, det_done;
  logic             act_sink, act_open, sourcing;

  cas_pin_decode #(.NPINS(NPINS)) dec_i (
    .rd(cc_rd), .ra(cc_ra), .open_f(cc_open),
    .sink(sink), .single(single), .sink_idx(sink_idx)
  );

  assign act_sink = sink[orient_q];
  assign act_open = cc_open[orient_q];
  assign sourcing = (state == ST_PWR) || (state == ST_DATA);

  cas_tick_timer #(.LIMIT(ATTACH_MS)) deb_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_DEB),
    .tick(ms_tick), .done(deb_done)
  );

  cas_tick_timer #(.LIMIT(DSW_MS)) dsw_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_PWR),
    .tick(ms_tick), .done(dsw_done)
  );

  cas_tick_timer #(.LIMIT(DETACH_MS)) det_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(!(sourcing && act_open)),
    .tick(ms_tick), .done(det_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (single && !fault && !cc_pu_off) state_nx = ST_DEB;
      ST_DEB: begin
        if (fault || cc_pu_off || !single || (sink_idx != orient_q))
          state_nx = ST_IDLE;
        else if (deb_done)
          state_nx = vbus_safe0v ? ST_PWR : ST_HOLD;
      end
      ST_HOLD: begin
        if (fault || !act_sink) state_nx = ST_IDLE;
        else if (vbus_safe0v)   state_nx = ST_PWR;
      end
      ST_PWR: begin
        if (fault || det_done) state_nx = ST_IDLE;
        else if (dsw_done)     state_nx = ST_DATA;
      end
      ST_DATA: if (fault || det_done) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      orient_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE) orient_q <= sink_idx;
    end
  end

  assign conv_en = sourcing;
  assign dsw_en  = (state == ST_DATA);
  assign req_5v  = sourcing;
  assign orient  = (state != ST_IDLE) & orient_q;
endmodule

// File: rtl/cas_attach_seq_chk.sv
module cas_attach_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic fault,
  input logic vbus_safe0v,
  input logic conv_en,
  input logic dsw_en,
  input logic orient,
  input logic req_5v
);
  a_r5_switch_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    dsw_en |-> conv_en);

  a_r7_fault_drops_enables: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!conv_en && !dsw_en));

  a_r4_power_after_discharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_en) |-> $past(vbus_safe0v));

  a_r6_joint_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsw_en) |-> !conv_en);

  a_r1_orient_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && $past(conv_en)) |-> $stable(orient));

  a_r9_request_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_5v) |-> conv_en);
endmodule

bind cas_attach_seq cas_attach_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fault(fault), .vbus_safe0v(vbus_safe0v),
  .conv_en(conv_en), .dsw_en(dsw_en), .orient(orient), .req_5v(req_5v)
);

// File: tb/cas_attach_seq_tb_top.sv
`timescale 1ns/1ps
module cas_attach_seq_tb_top;
  localparam int ATT = 6;
  localparam int DET = 3;
  localparam int DSW = 10;
  localparam int TDIV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic [1:0] cc_rd = 2'b00, cc_ra = 2'b00, cc_open = 2'b11;
  logic vbus_safe0v = 1'b1, fault = 1'b0, cc_pu_off = 1'b0;
  logic conv_en, dsw_en, orient, req_5v;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cas_attach_seq #(.ATTACH_MS(ATT), .DETACH_MS(DET), .DSW_MS(DSW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .cc_rd(cc_rd), .cc_ra(cc_ra), .cc_open(cc_open),
    .vbus_safe0v(vbus_safe0v), .fault(fault), .cc_pu_off(cc_pu_off),
    .conv_en(conv_en), .dsw_en(dsw_en), .orient(orient), .req_5v(req_5v)
  );

  // reference model: phase 0 idle, 1 debounce, 2 wait VBUS, 3 powered, 4 data on
  int m_ph = 0, m_ac = 0, m_dc = 0, m_wc = 0;
  logic m_ori = 1'b0;

  always @(posedge clk) begin
    logic [1:0] snk;
    logic one, who;
    snk = cc_rd & ~cc_ra & ~cc_open;
    one = (snk == 2'b01) || (snk == 2'b10);
    who = snk[1];
    if (!rst_n) begin
      m_ph <= 0; m_ori <= 1'b0; m_ac <= 0; m_dc <= 0; m_wc <= 0;
    end else begin
      case (m_ph)
        0: begin
          m_ac <= 0; m_dc <= 0; m_wc <= 0;
          if (one && !fault && !cc_pu_off) begin m_ph <= 1; m_ori <= who; end
        end
        1: begin
          if (fault || cc_pu_off || !one || who != m_ori) m_ph <= 0;
          else if (m_ac == ATT) m_ph <= vbus_safe0v ? 3 : 2;
          else if (ms_tick) m_ac <= m_ac + 1;
        end
        2: begin
          m_dc <= 0; m_wc <= 0;
          if (fault || !snk[m_ori]) m_ph <= 0;
          else if (vbus_safe0v) m_ph <= 3;
        end
        default: begin
          if (fault || m_dc == DET) m_ph <= 0;
          else if (m_ph == 3 && m_wc == DSW) m_ph <= 4;
          if (!cc_open[m_ori]) m_dc <= 0;
          else if (ms_tick && m_dc != DET) m_dc <= m_dc + 1;
          if (m_ph == 3 && ms_tick && m_wc != DSW) m_wc <= m_wc + 1;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R3 R4 R6 R7 R8 conv_en", conv_en, (m_ph == 3 || m_ph == 4));
      chk("R5 R6 R7 dsw_en", dsw_en, (m_ph == 4));
      chk("R1 R2 orient", orient, (m_ph != 0) ? m_ori : 1'b0);
      chk("R9 req_5v", req_5v, (m_ph == 3 || m_ph == 4));
    end
  end

  initial begin : tick_gen
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  task automatic ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic pins(input logic [1:0] rd, input logic [1:0] ra, input logic [1:0] op);
    cc_rd = rd; cc_ra = ra; cc_open = op;
  endtask

  function automatic logic [5:0] pick_pins(input int sel);
    case (sel)
      0, 1: return {2'b01, 2'b00, 2'b10};
      2, 3: return {2'b10, 2'b00, 2'b01};
      4:    return {2'b10, 2'b01, 2'b00};
      5:    return {2'b00, 2'b00, 2'b11};
      6:    return {2'b11, 2'b00, 2'b00};
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    // R10: outputs during reset
    chk("R10 conv_en in reset", conv_en, 1'b0);
    chk("R10 dsw_en in reset", dsw_en, 1'b0);
    chk("R10 orient in reset", orient, 1'b0);
    chk("R10 req_5v in reset", req_5v, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 conv_en after reset", conv_en, 1'b0);

    // R1 attach on CC1, then full detach (R6)
    pins(2'b01, 2'b00, 2'b10); ticks(25);
    chk("R5 dsw_en on after delay", dsw_en, 1'b1);
    pins(2'b00, 2'b00, 2'b11); ticks(6);
    // R2 attach on CC2 with marker on CC1
    pins(2'b10, 2'b01, 2'b00); ticks(25);
    chk("R2 orient CC2", orient, 1'b1);
    // R6 short open blip on active pin is ignored
    pins(2'b00, 2'b01, 2'b10); ticks(1);
    pins(2'b10, 2'b01, 2'b00); ticks(3);
    chk("R6 blip ignored", conv_en, 1'b1);
    // R7 fault pulse, then re-attach
    fault = 1'b1; repeat (3) @(negedge clk); fault = 1'b0;
    ticks(25);
    pins(2'b00, 2'b00, 2'b11); ticks(6);
    // R2 both pins Rd: no attach
    pins(2'b11, 2'b00, 2'b00); ticks(12);
    chk("R2 dual Rd no power", conv_en, 1'b0);
    // R4 VBUS present at debounce end
    pins(2'b00, 2'b00, 2'b11); ticks(3);
    vbus_safe0v = 1'b0; pins(2'b01, 2'b00, 2'b10); ticks(15);
    chk("R4 held off by VBUS", conv_en, 1'b0);
    vbus_safe0v = 1'b1; ticks(15);
    pins(2'b00, 2'b00, 2'b11); ticks(6);
    // R8 pull-ups off blocks attach
    cc_pu_off = 1'b1; pins(2'b10, 2'b00, 2'b01); ticks(12);
    chk("R8 no attach while pull-ups off", conv_en, 1'b0);
    cc_pu_off = 1'b0; ticks(15);
    // R3 debounce interruption
    pins(2'b00, 2'b00, 2'b11); ticks(5);
    pins(2'b01, 2'b00, 2'b10); ticks(3);
    pins(2'b00, 2'b00, 2'b11); @(negedge clk);
    pins(2'b01, 2'b00, 2'b10); ticks(4);
    chk("R3 debounce restarted", conv_en, 1'b0);
    ticks(10);

    // constrained random phase
    for (int it = 0; it < 400; it++) begin
      logic [5:0] p;
      p = pick_pins(int'($urandom_range(0, 8)));
      pins(p[5:4], p[3:2], p[1:0]);
      fault       = ($urandom_range(0, 15) == 0);
      cc_pu_off   = ($urandom_range(0, 15) == 0);
      vbus_safe0v = ($urandom_range(0, 7) != 0);
      repeat (int'($urandom_range(1, 20 * TDIV))) @(negedge clk);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule